// File: doc/BRIEF.md
# Banked MSI Vector Capture and Interrupt Aggregator

This block turns inbound message-signalled interrupt writes into pending vector bits. The vectors are split into banks of 32. Each bank has its own doorbell address register. An inbound write whose address equals a bank's doorbell address sets one bit in that bank. The written data value selects which bit. Software reads the pending bits, clears them by writing ones, and masks them per vector through a per-bank enable register.

A top-level status register collects the banks. Each bank owns one summary bit there, and that bit is set while the bank holds any pending vector that is also enabled. The same register also carries four level-style legacy interrupt lines. Their levels arrive already decoded on `intx_level`. The summary bits and the legacy bits are each gated by a top-level enable register. Any bit that is both set and enabled drives the single host interrupt `irq_out`. A separate bank-accept register decides which banks may take inbound writes at all.

Top module: `msi_aggregator`

## Requirements
- R1: After reset, every register reads as zero and `irq_out` is low.
- R2: Bank b's registers sit at 0xC00 + 0x10·b. The doorbell address is at +0x0, the pending status at +0x4 and the vector enable at +0x8. The doorbell address and the vector enable read back what was last written.
- R3: An inbound write captures when three conditions hold: `msi_addr` equals bank b's doorbell address, bit b of the bank-accept register (0x190) is 1, and `msi_data` is below 32. It then sets status bit `msi_data` of bank b on the next clock edge.
- R4: An inbound write changes no state when it matches no doorbell, when it targets only a bank whose accept bit is 0, or when its data is 32 or more.
- R5: Writing a 1 to a status bit clears it. If an inbound capture hits the same bit in the same cycle, the capture wins and the bit stays set.
- R6: Top status bit 8+b (0x184) is set one cycle after bank b holds a bit that is both pending and enabled. A write-1 clears it for one cycle, and it sets again on the following cycle while such a bit remains.
- R7: Top status bit 24+i follows `intx_level[i]` high and stays set after the level drops. A write-1 clears it only while the level is low.
- R8: Top enable (0x180) stores only bits 8–15 and 24–27, and the other bits read 0. `irq_out` is high exactly when some top status bit and its enable bit are both 1.
- R9: When several accepting banks share a doorbell address, only the lowest-numbered of them captures the write.
- R10: The bank-accept register (0x190) stores bits 0–7, and the upper bits read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msi_valid | input | 1 | Inbound message write strobe |
| msi_addr | input | 32 | Inbound message write address |
| msi_data | input | 32 | Inbound message write data (vector index) |
| intx_level | input | 4 | Decoded levels of the four legacy interrupt lines |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| irq_out | output | 1 | Host interrupt |

## Verification
Each state fault shows up at the register port, and most show up within one or two cycles:
- A wrong decode of the vector index or bank sets the wrong status bit. That is visible on the combinational read in the cycle after the capture edge.
- A faulty summary term shows one cycle later, both in the top status register and on `irq_out`.
- A wrong clear priority, a sticky-versus-level error on the legacy lines, or a missed re-arm after a write-1 clear shows on the read right after the clearing edge or one edge later.
- A leak through the accept gate or the data range check shows as a nonzero bank status on the read that follows the dropped write.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
    localparam logic [11:0] BANK_BASE   = 12'hC00;
    localparam int          BANK_STRIDE = 16;
    localparam logic [11:0] OFF_DOORBELL = 12'h000;
    localparam logic [11:0] OFF_PENDING  = 12'h004;
    localparam logic [11:0] OFF_VEC_EN   = 12'h008;
    localparam logic [11:0] TOP_EN_ADDR  = 12'h180;
    localparam logic [11:0] TOP_STS_ADDR = 12'h184;
    localparam logic [11:0] ACCEPT_ADDR  = 12'h190;
    localparam int          SUM_LSB      = 8;
    localparam int          LEG_LSB      = 24;
    localparam int          NUM_LEG      = 4;
endpackage

// File: rtl/msi_bank.sv
module msi_bank #(
    parameter int VEC_PER_BANK = 32,
    localparam int VEC_W = $clog2(VEC_PER_BANK)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    doorbell_we,
    input  logic                    pending_we,
    input  logic                    vec_en_we,
    input  logic [31:0]             wdata,
    input  logic                    cap_en,
    input  logic [VEC_W-1:0]        cap_idx,
    output logic [31:0]             doorbell,
    output logic [VEC_PER_BANK-1:0] pending,
    output logic [VEC_PER_BANK-1:0] vec_en,
    output logic                    pend_any
);
    typedef struct packed {
        logic [31:0]             dbell;
        logic [VEC_PER_BANK-1:0] pend;
        logic [VEC_PER_BANK-1:0] en;
    } bank_st_t;

    bank_st_t st_d, st_q;
    logic [VEC_PER_BANK-1:0] clr_vec, set_vec;

    always_comb begin
        st_d    = st_q;
        clr_vec = pending_we ? wdata[VEC_PER_BANK-1:0] : '0;
        set_vec = cap_en ? (VEC_PER_BANK'(1) << cap_idx) : '0;
        if (doorbell_we) st_d.dbell = wdata;
        if (vec_en_we)   st_d.en    = wdata[VEC_PER_BANK-1:0];
        st_d.pend = (st_q.pend & ~clr_vec) | set_vec;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign doorbell = st_q.dbell;
    assign pending  = st_q.pend;
    assign vec_en   = st_q.en;
    assign pend_any = |(st_q.pend & st_q.en);

    // R3 R5
    capture_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap_en |=> st_q.pend[$past(cap_idx)]);

    // R4
    no_spurious_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.pend & ~$past(st_q.pend)) != '0) |-> $past(cap_en));
endmodule

// File: rtl/msi_top_irq.sv
module msi_top_irq
    import msi_agg_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en_we,
    input  logic                 sts_we,
    input  logic [NUM_BANKS-1:0] w_sum,
    input  logic [NUM_LEG-1:0]   w_leg,
    input  logic [NUM_BANKS-1:0] bank_pend,
    input  logic [NUM_LEG-1:0]   intx_level,
    output logic [NUM_BANKS-1:0] sum_en,
    output logic [NUM_LEG-1:0]   leg_en,
    output logic [NUM_BANKS-1:0] sum_sts,
    output logic [NUM_LEG-1:0]   leg_sts,
    output logic                 irq
);
    typedef struct packed {
        logic [NUM_BANKS-1:0] sum_en;
        logic [NUM_LEG-1:0]   leg_en;
        logic [NUM_BANKS-1:0] sum_sts;
        logic [NUM_LEG-1:0]   leg_sts;
    } top_st_t;

    top_st_t st_d, st_q;
    logic [NUM_BANKS-1:0] sum_clr;
    logic [NUM_LEG-1:0]   leg_clr;

    always_comb begin
        st_d    = st_q;
        sum_clr = sts_we ? w_sum : '0;
        leg_clr = sts_we ? w_leg : '0;
        if (en_we) begin
            st_d.sum_en = w_sum;
            st_d.leg_en = w_leg;
        end
        st_d.sum_sts = (st_q.sum_sts | bank_pend) & ~sum_clr;
        st_d.leg_sts = intx_level | (st_q.leg_sts & ~leg_clr);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sum_en  = st_q.sum_en;
    assign leg_en  = st_q.leg_en;
    assign sum_sts = st_q.sum_sts;
    assign leg_sts = st_q.leg_sts;
    assign irq     = |(st_q.sum_sts & st_q.sum_en) | |(st_q.leg_sts & st_q.leg_en);

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_sum_chk
        // R6
        summary_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (bank_pend[b] && !(sts_we && w_sum[b])) |=> st_q.sum_sts[b]);
    end

    for (genvar i = 0; i < NUM_LEG; i++) begin : g_leg_chk
        // R7
        legacy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            intx_level[i] |=> st_q.leg_sts[i]);
    end
endmodule

// File: rtl/msi_aggregator.sv
module msi_aggregator
    import msi_agg_pkg::*;
#(
    parameter int NUM_BANKS    = 8,
    parameter int VEC_PER_BANK = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        msi_valid,
    input  logic [31:0] msi_addr,
    input  logic [31:0] msi_data,
    input  logic [3:0]  intx_level,
    input  logic        reg_we,
    input  logic [11:0] reg_addr,
    input  logic [31:0] reg_wdata,
    output logic [31:0] reg_rdata,
    output logic        irq_out
);
    localparam int VEC_W  = $clog2(VEC_PER_BANK);
    localparam int FLAT_W = NUM_BANKS * VEC_PER_BANK;

    typedef struct packed {
        logic [NUM_BANKS-1:0] accept;
    } agg_st_t;

    agg_st_t st_d, st_q;

    logic [31:0]             bank_dbell [NUM_BANKS];
    logic [VEC_PER_BANK-1:0] bank_pend  [NUM_BANKS];
    logic [VEC_PER_BANK-1:0] bank_en    [NUM_BANKS];
    logic [NUM_BANKS-1:0]    bank_any;
    logic [NUM_BANKS-1:0]    hit;
    logic [NUM_BANKS-1:0]    take;
    logic [FLAT_W-1:0]       pend_flat;
    logic                    data_ok;
    logic                    found;

    logic [NUM_BANKS-1:0] sum_en, sum_sts;
    logic [NUM_LEG-1:0]   leg_en, leg_sts;
    logic                 top_en_we, top_sts_we, accept_we;

    assign data_ok    = (msi_data[31:VEC_W] == '0);
    assign top_en_we  = reg_we && (reg_addr == TOP_EN_ADDR);
    assign top_sts_we = reg_we && (reg_addr == TOP_STS_ADDR);
    assign accept_we  = reg_we && (reg_addr == ACCEPT_ADDR);

    always_comb begin
        st_d = st_q;
        if (accept_we) st_d.accept = reg_wdata[NUM_BANKS-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // lowest-numbered matching bank takes the write
    always_comb begin
        take  = '0;
        found = 1'b0;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (!found && hit[b]) begin
                take[b] = 1'b1;
                found   = 1'b1;
            end
        end
    end

    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        localparam logic [11:0] BBASE = BANK_BASE + 12'(b * BANK_STRIDE);
        logic db_we, pd_we, ve_we;

        assign db_we  = reg_we && (reg_addr == BBASE + OFF_DOORBELL);
        assign pd_we  = reg_we && (reg_addr == BBASE + OFF_PENDING);
        assign ve_we  = reg_we && (reg_addr == BBASE + OFF_VEC_EN);
        assign hit[b] = msi_valid && data_ok && st_q.accept[b]
                        && (msi_addr == bank_dbell[b]);
        assign pend_flat[b*VEC_PER_BANK +: VEC_PER_BANK] = bank_pend[b];

        msi_bank #(.VEC_PER_BANK(VEC_PER_BANK)) u_bank (
            .clk         (clk),
            .rst_n       (rst_n),
            .doorbell_we (db_we),
            .pending_we  (pd_we),
            .vec_en_we   (ve_we),
            .wdata       (reg_wdata),
            .cap_en      (take[b]),
            .cap_idx     (msi_data[VEC_W-1:0]),
            .doorbell    (bank_dbell[b]),
            .pending     (bank_pend[b]),
            .vec_en      (bank_en[b]),
            .pend_any    (bank_any[b])
        );
    end

    msi_top_irq #(.NUM_BANKS(NUM_BANKS)) u_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .en_we      (top_en_we),
        .sts_we     (top_sts_we),
        .w_sum      (reg_wdata[SUM_LSB +: NUM_BANKS]),
        .w_leg      (reg_wdata[LEG_LSB +: NUM_LEG]),
        .bank_pend  (bank_any),
        .intx_level (intx_level),
        .sum_en     (sum_en),
        .leg_en     (leg_en),
        .sum_sts    (sum_sts),
        .leg_sts    (leg_sts),
        .irq        (irq_out)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == TOP_EN_ADDR) begin
            reg_rdata[SUM_LSB +: NUM_BANKS] = sum_en;
            reg_rdata[LEG_LSB +: NUM_LEG]   = leg_en;
        end
        if (reg_addr == TOP_STS_ADDR) begin
            reg_rdata[SUM_LSB +: NUM_BANKS] = sum_sts;
            reg_rdata[LEG_LSB +: NUM_LEG]   = leg_sts;
        end
        if (reg_addr == ACCEPT_ADDR)
            reg_rdata[NUM_BANKS-1:0] = st_q.accept;
        for (int b = 0; b < NUM_BANKS; b++) begin
            if (reg_addr == BANK_BASE + 12'(b * BANK_STRIDE) + OFF_DOORBELL)
                reg_rdata = bank_dbell[b];
            if (reg_addr == BANK_BASE + 12'(b * BANK_STRIDE) + OFF_PENDING)
                reg_rdata = 32'(bank_pend[b]);
            if (reg_addr == BANK_BASE + 12'(b * BANK_STRIDE) + OFF_VEC_EN)
                reg_rdata = 32'(bank_en[b]);
        end
    end

    // R9
    single_taker_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(take));

    // R4
    drop_keeps_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (msi_valid && !reg_we && !(|hit)) |=> $stable(pend_flat));
endmodule

// File: tb/msi_aggregator_test.sv
module msi_aggregator_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        msi_valid = 1'b0;
    logic [31:0] msi_addr = '0;
    logic [31:0] msi_data = '0;
    logic [3:0]  intx_level = '0;
    logic        reg_we = 1'b0;
    logic [11:0] reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq_out;

    int nchk = 0;
    int nerr = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    msi_aggregator uut (
        .clk(clk), .rst_n(rst_n), .msi_valid(msi_valid), .msi_addr(msi_addr),
        .msi_data(msi_data), .intx_level(intx_level), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq_out(irq_out)
    );

    function automatic logic [31:0] dbell_of(int b);
        return 32'h8000_0000 + 32'(b) * 32'h100;
    endfunction
    function automatic logic [11:0] breg(int b, int off);
        return 12'hC00 + 12'(b * 16 + off);
    endfunction

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s: got %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic msi(logic [31:0] a, logic [31:0] d);
        msi_valid = 1'b1; msi_addr = a; msi_data = d;
        @(negedge clk);
        msi_valid = 1'b0;
    endtask

    task automatic rd(logic [11:0] a, output logic [31:0] v);
        reg_addr = a;
        #1;
        v = reg_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_all();
        for (int b = 0; b < 8; b++) wr(breg(b, 4), 32'hFFFF_FFFF);
        wr(12'h184, 32'hFFFF_FFFF);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1 reset state
        for (int b = 0; b < 8; b++) begin
            for (int o = 0; o < 12; o += 4) begin
                rd(breg(b, o), v); chk("R1 bank reg", v, 0);
            end
        end
        rd(12'h180, v); chk("R1 top enable", v, 0);
        rd(12'h184, v); chk("R1 top status", v, 0);
        rd(12'h190, v); chk("R1 accept", v, 0);
        chk("R1 irq", 32'(irq_out), 0);

        // R2 doorbell and enable readback
        for (int b = 0; b < 8; b++) begin
            wr(breg(b, 0), dbell_of(b));
            wr(breg(b, 8), 32'hFFFF_FFFF ^ (32'(b) << 4));
        end
        for (int b = 0; b < 8; b++) begin
            rd(breg(b, 0), v); chk("R2 doorbell", v, dbell_of(b));
            rd(breg(b, 8), v); chk("R2 vec enable", v, 32'hFFFF_FFFF ^ (32'(b) << 4));
            wr(breg(b, 8), 32'hFFFF_FFFF);
        end

        // R10 accept register width
        wr(12'h190, 32'hFFFF_FFFF);
        rd(12'h190, v); chk("R10 accept", v, 32'h0000_00FF);

        // R8 top enable stored bits
        wr(12'h180, 32'hFFFF_FFFF);
        rd(12'h180, v); chk("R8 top enable mask", v, 32'h0F00_FF00);

        // R3 R5 R6 R8 sweep every bank and vector
        for (int b = 0; b < 8; b++) begin
            for (int k = 0; k < 32; k++) begin
                msi(dbell_of(b), 32'(k));
                rd(breg(b, 4), v); chk("R3 capture", v, 32'h1 << k);
                idle(1);
                rd(12'h184, v); chk("R6 summary set", v, 32'h1 << (8 + b));
                chk("R8 irq on", 32'(irq_out), 1);
                wr(breg(b, 4), 32'h1 << k);
                rd(breg(b, 4), v); chk("R5 w1c", v, 0);
                wr(12'h184, 32'h1 << (8 + b));
                rd(12'h184, v); chk("R6 summary clear", v, 0);
                chk("R8 irq off", 32'(irq_out), 0);
            end
        end

        // R6 re-arm while still pending
        msi(dbell_of(2), 32'd9);
        idle(1);
        wr(12'h184, 32'h1 << 10);
        rd(12'h184, v); chk("R6 cleared one cycle", v, 0);
        idle(1);
        rd(12'h184, v); chk("R6 re-armed", v, 32'h1 << 10);
        // R6 masked vector does not summarize
        wr(breg(2, 8), 32'h0);
        wr(12'h184, 32'h1 << 10);
        idle(2);
        rd(12'h184, v); chk("R6 masked vector", v, 0);
        wr(breg(2, 8), 32'hFFFF_FFFF);
        clear_all();

        // R8 enable gates irq
        wr(12'h180, 32'h0);
        msi(dbell_of(4), 32'd1);
        idle(1);
        chk("R8 irq masked", 32'(irq_out), 0);
        wr(12'h180, 32'h1 << 12);
        chk("R8 irq enabled", 32'(irq_out), 1);
        wr(12'h180, 32'h0F00_FF00);
        clear_all();

        // R5 capture wins over same-cycle clear
        msi(dbell_of(0), 32'd3);
        reg_we = 1'b1; reg_addr = breg(0, 4); reg_wdata = 32'h8;
        msi_valid = 1'b1; msi_addr = dbell_of(0); msi_data = 32'd3;
        @(negedge clk);
        reg_we = 1'b0; msi_valid = 1'b0;
        rd(breg(0, 4), v); chk("R5 capture wins", v, 32'h8);
        reg_we = 1'b1; reg_addr = breg(0, 4); reg_wdata = 32'h8;
        msi_valid = 1'b1; msi_addr = dbell_of(0); msi_data = 32'd4;
        @(negedge clk);
        reg_we = 1'b0; msi_valid = 1'b0;
        rd(breg(0, 4), v); chk("R5 clear plus other set", v, 32'h10);
        clear_all();

        // R4 drops
        wr(12'h190, 32'hFB);
        msi(dbell_of(2), 32'd5);
        msi(dbell_of(1), 32'd32);
        msi(dbell_of(1), 32'hFFFF_FFFF);
        msi(32'h0000_1234, 32'd0);
        idle(1);
        for (int b = 0; b < 8; b++) begin
            rd(breg(b, 4), v); chk("R4 dropped write", v, 0);
            rd(breg(b, 0), v); chk("R4 doorbell intact", v, dbell_of(b));
        end
        rd(12'h184, v); chk("R4 top untouched", v, 0);
        chk("R4 irq low", 32'(irq_out), 0);
        wr(12'h190, 32'hFF);

        // R9 shared doorbell
        wr(breg(5, 0), dbell_of(3));
        msi(dbell_of(3), 32'd7);
        rd(breg(3, 4), v); chk("R9 lower bank takes", v, 32'h80);
        rd(breg(5, 4), v); chk("R9 upper bank idle", v, 0);
        wr(12'h190, 32'hF7);
        msi(dbell_of(3), 32'd6);
        rd(breg(5, 4), v); chk("R9 falls to next accepting", v, 32'h40);
        rd(breg(3, 4), v); chk("R9 gated bank unchanged", v, 32'h80);
        wr(12'h190, 32'hFF);
        wr(breg(5, 0), dbell_of(5));
        idle(1);
        clear_all();

        // R7 legacy lines
        for (int i = 0; i < 4; i++) begin
            intx_level = 4'(1 << i);
            idle(1);
            rd(12'h184, v); chk("R7 level sets", v, 32'h1 << (24 + i));
            chk("R7 irq", 32'(irq_out), 1);
            wr(12'h184, 32'h1 << (24 + i));
            rd(12'h184, v); chk("R7 clear ignored while high", v, 32'h1 << (24 + i));
            intx_level = 4'h0;
            idle(1);
            rd(12'h184, v); chk("R7 sticky after drop", v, 32'h1 << (24 + i));
            wr(12'h184, 32'h1 << (24 + i));
            rd(12'h184, v); chk("R7 clear when low", v, 0);
            chk("R7 irq off", 32'(irq_out), 0);
        end

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end
endmodule